// File: doc/BRIEF.md
# Multi-Level Virtual Address Translation Walker

This block turns a 64-bit virtual address into a real address by reading translation-table entries from memory, one level at a time. A walk can begin at any of four table levels: region-first, region-second, region-third or segment. It then descends toward the page table. A 2 GB frame at the region-third level or a 1 MB frame at the segment level can end the walk early. At each step the block checks the index against the table's offset and length bounds. It also checks the entry's invalid bit, its table type and its common-bit rules. A DAT-protection bit is gathered across the levels, and a store that reaches a protected frame is refused.

A caller pulses `start` together with the address-space control word (ASCE), the virtual address, a store/fetch flag and two large-frame enables. The walker issues 64-bit entry reads over a simple request/response port and keeps one read outstanding at a time. When the walk ends, it raises `done` for exactly one cycle, carrying either the translated address or a program exception code.

The controller is a one-hot machine with six states:

- `ST_IDLE` waits for `start`. From there it goes to `ST_DONE` when the real-space bit is set, to `ST_FAULT` when the start checks fail, to `ST_FETCH_SEG` when the walk begins at the segment level, and to `ST_FETCH_RGN` otherwise.
- `ST_FETCH_RGN` serves all three region levels, with a level register counting down. It stays in this state for the next region level, moves to `ST_FETCH_SEG` after region-third, or ends in `ST_DONE` (2 GB frame) or `ST_FAULT`.
- `ST_FETCH_SEG` goes to `ST_FETCH_PTE`, `ST_DONE` (1 MB frame) or `ST_FAULT`.
- `ST_FETCH_PTE` goes to `ST_DONE` or `ST_FAULT`.
- `ST_DONE` and `ST_FAULT` each last one cycle and return to `ST_IDLE`.

Top module: `xlate_walker`

## Requirements
- R1: When ASCE bit 5 (real-space) is set, no table read is made. `done` rises on the cycle after `start` is taken, with `fault` low and `result_addr` equal to the virtual address.
- R2: ASCE bits [3:2] select the first table: 3 region-first (index VA[63:53]), 2 region-second (VA[52:42]), 1 region-third (VA[41:31]), 0 segment (VA[30:20]). The first read address is ASCE[63:12]×4096 plus that index ×8, and every read address is a multiple of 8.
- R3: If any index field above the starting level is nonzero, the walk ends with code 0x38 and no read is made.
- R4: If the top two bits of the first index exceed ASCE[1:0], the walk ends with that level's code: 0x39 region-first, 0x3A region-second, 0x3B region-third, 0x10 segment.
- R5: In a region entry, bit 5 set gives the code of the entry's own level. Otherwise, entry bits [3:2] differing from the level number (3, 2, 1) give 0x12.
- R6: In a valid region entry, if the top two bits of the next index are below entry bits [7:6] or above entry bits [1:0], the walk ends with the next level's code. Otherwise the next read is at entry[63:12]×4096 plus the next index ×8.
- R7: The second large-frame level is active only when both enables are high. When it is active, a region-third entry with bit 4 set under ASCE bit 8 gives 0x12. Otherwise, with entry bit 10 set, the walk ends with result {entry[63:31], VA[30:0]}.
- R8: A segment entry gives 0x10 if bit 5 is set, and 0x12 if bits [3:2] are nonzero or if bit 4 is set under ASCE bit 8. With bit 10 set and the first large-frame enable high, the result is {entry[63:20], VA[19:0]}. Otherwise the page entry is read at entry[63:11]×2048 plus VA[19:12]×8.
- R9: A page entry gives 0x11 if bit 10 is set and 0x12 if bit 11 is set. Otherwise the result is {entry[63:12], VA[11:0]}.
- R10: Bit 9 (protection) of region entries counts only when the first large-frame enable is high. Bit 9 of the region-third large-frame entry, of segment entries and of page entries always counts. A store whose accumulated protection is set ends with 0x04; a fetch does not.
- R11: `done` is high for exactly one cycle per walk. With `fault` high, `exc_code` is nonzero; with `fault` low, `exc_code` is 0.
- R12: At most one read is outstanding. `mem_req` and `mem_addr` hold steady until `mem_rsp_valid` is seen.
- R13: A `start` that arrives while a walk is in progress is ignored and does not disturb that walk's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a walk (taken only when idle) |
| asce | input | 64 | Address-space control word |
| vaddr | input | 64 | Virtual address to translate |
| is_store | input | 1 | 1 = store access, 0 = fetch |
| lf1_en | input | 1 | Enables 1 MB frames and region protection bits |
| lf2_en | input | 1 | Enables 2 GB frames (only together with lf1_en) |
| mem_req | output | 1 | Entry read request, held until response |
| mem_addr | output | 64 | Entry read address |
| mem_rsp_valid | input | 1 | Entry data valid |
| mem_rsp_data | input | 64 | Entry data |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | With done: walk ended in an exception |
| result_addr | output | 64 | Translated address (valid with done and not fault) |
| exc_code | output | 8 | Exception code (valid with done) |

## Verification
A corrupted level register or protection bit shows up at the ports on the same walk. The read address goes wrong on the very next request, or the final `done` carries a wrong code, a wrong frame, or an unwarranted 0x04. The bench sweeps every start level against a set of single-point table defects, both access kinds and all four enable combinations. It compares each outcome, and the first read address of clean walks, with a table-walking model written from the requirements. A stuck state shows either as an address that changes while a request is still waiting, or as `done` lasting longer than one cycle.

// File: rtl/xw_pkg.sv
package xw_pkg;
    localparam int VA_W  = 64;
    localparam int ENT_W = 64;
    localparam int IDX_W = 11;
    localparam int PX_W  = 8;
    localparam int EXC_W = 8;
    localparam int LVL_W = 2;

    typedef logic [EXC_W-1:0] exc_t;

    localparam exc_t EXC_NONE      = 8'h00;
    localparam exc_t EXC_PROT      = 8'h04;
    localparam exc_t EXC_SEG       = 8'h10;
    localparam exc_t EXC_PAGE      = 8'h11;
    localparam exc_t EXC_TSPEC     = 8'h12;
    localparam exc_t EXC_ASCE_TYPE = 8'h38;
    localparam exc_t EXC_RGN1      = 8'h39;
    localparam exc_t EXC_RGN2      = 8'h3A;
    localparam exc_t EXC_RGN3      = 8'h3B;

    localparam logic [LVL_W-1:0] LVL_SEG  = 2'd0;
    localparam logic [LVL_W-1:0] LVL_RGN3 = 2'd1;
    localparam logic [LVL_W-1:0] LVL_RGN2 = 2'd2;
    localparam logic [LVL_W-1:0] LVL_RGN1 = 2'd3;

    typedef enum logic [5:0] {
        ST_IDLE      = 6'b000001,
        ST_FETCH_RGN = 6'b000010,
        ST_FETCH_SEG = 6'b000100,
        ST_FETCH_PTE = 6'b001000,
        ST_DONE      = 6'b010000,
        ST_FAULT     = 6'b100000
    } walk_state_t;

    // translation exception belonging to a table level
    function automatic exc_t level_exc(input logic [LVL_W-1:0] lvl);
        case (lvl)
            LVL_RGN1: return EXC_RGN1;
            LVL_RGN2: return EXC_RGN2;
            LVL_RGN3: return EXC_RGN3;
            default:  return EXC_SEG;
        endcase
    endfunction

    // index field of the virtual address that selects an entry at a level
    function automatic logic [IDX_W-1:0] level_index(input logic [VA_W-1:0] va,
                                                     input logic [LVL_W-1:0] lvl);
        case (lvl)
            LVL_RGN1: return va[63:53];
            LVL_RGN2: return va[52:42];
            LVL_RGN3: return va[41:31];
            default:  return va[30:20];
        endcase
    endfunction
endpackage

// File: rtl/xw_start_check.sv
module xw_start_check
    import xw_pkg::*;
(
    input  logic [VA_W-13:0]  origin,
    input  logic [LVL_W-1:0]  dtype,
    input  logic [1:0]        tlen,
    input  logic [VA_W-1:0]   vaddr,
    output logic              fail,
    output exc_t              fail_code,
    output logic [VA_W-1:0]   first_ptr
);
    logic [IDX_W-1:0] idx;
    logic             upper_nz;

    assign idx = level_index(vaddr, dtype);

    always_comb begin
        unique case (dtype)
            LVL_RGN1: upper_nz = 1'b0;
            LVL_RGN2: upper_nz = |vaddr[63:53];
            LVL_RGN3: upper_nz = |vaddr[63:42];
            default:  upper_nz = |vaddr[63:31];
        endcase
    end

    always_comb begin
        fail      = 1'b0;
        fail_code = EXC_NONE;
        if (upper_nz) begin
            fail      = 1'b1;
            fail_code = EXC_ASCE_TYPE;
        end else if (idx[IDX_W-1 -: 2] > tlen) begin
            fail      = 1'b1;
            fail_code = level_exc(dtype);
        end
    end

    assign first_ptr = {origin, 12'h000} + VA_W'({idx, 3'b000});
endmodule

// File: rtl/xw_entry_eval.sv
module xw_entry_eval
    import xw_pkg::*;
(
    input  logic              is_rgn,
    input  logic              is_seg,
    input  logic              is_pte,
    input  logic [LVL_W-1:0]  lvl,
    input  logic [ENT_W-1:0]  entry,
    input  logic [VA_W-1:0]   vaddr,
    input  logic              priv,
    input  logic              lf1,
    input  logic              lf2e,
    input  logic              is_store,
    input  logic              prot_in,
    output logic              fail,
    output exc_t              fail_code,
    output logic              finish,
    output logic [VA_W-1:0]   next_ptr,
    output logic              prot_out,
    output logic [VA_W-1:0]   frame
);
    logic [LVL_W-1:0] nlvl;
    logic [IDX_W-1:0] nidx;
    logic [1:0]       ntop;
    logic [PX_W-1:0]  px;
    logic             bad;
    exc_t             code;
    logic             hit;
    logic             prot;
    logic             unused_ent;

    assign nlvl       = lvl - 2'd1;
    assign nidx       = level_index(vaddr, nlvl);
    assign ntop       = nidx[IDX_W-1 -: 2];
    assign px         = vaddr[19:12];
    assign unused_ent = entry[8];

    always_comb begin
        bad      = 1'b0;
        code     = EXC_NONE;
        hit      = 1'b0;
        next_ptr = '0;
        prot     = prot_in;
        frame    = '0;
        if (is_rgn) begin
            if (entry[5]) begin
                bad  = 1'b1;
                code = level_exc(lvl);
            end else if (entry[3:2] != lvl) begin
                bad  = 1'b1;
                code = EXC_TSPEC;
            end else if (lvl == LVL_RGN3 && lf2e && entry[4] && priv) begin
                bad  = 1'b1;
                code = EXC_TSPEC;
            end else if (lvl == LVL_RGN3 && lf2e && entry[10]) begin
                hit   = 1'b1;
                prot  = prot_in | entry[9];
                frame = {entry[63:31], vaddr[30:0]};
            end else if (ntop < entry[7:6] || ntop > entry[1:0]) begin
                bad  = 1'b1;
                code = level_exc(nlvl);
            end else begin
                prot     = prot_in | (entry[9] & lf1);
                next_ptr = {entry[63:12], 12'h000} + VA_W'({nidx, 3'b000});
            end
        end else if (is_seg) begin
            if (entry[5]) begin
                bad  = 1'b1;
                code = EXC_SEG;
            end else if (entry[3:2] != LVL_SEG || (entry[4] && priv)) begin
                bad  = 1'b1;
                code = EXC_TSPEC;
            end else if (entry[10] && lf1) begin
                hit   = 1'b1;
                prot  = prot_in | entry[9];
                frame = {entry[63:20], vaddr[19:0]};
            end else begin
                prot     = prot_in | entry[9];
                next_ptr = {entry[63:11], 11'h000} + VA_W'({px, 3'b000});
            end
        end else if (is_pte) begin
            if (entry[10]) begin
                bad  = 1'b1;
                code = EXC_PAGE;
            end else if (entry[11]) begin
                bad  = 1'b1;
                code = EXC_TSPEC;
            end else begin
                hit   = 1'b1;
                prot  = prot_in | entry[9];
                frame = {entry[63:12], vaddr[11:0]};
            end
        end
    end

    always_comb begin
        fail      = bad;
        fail_code = code;
        finish    = hit;
        prot_out  = prot;
        if (hit && is_store && prot) begin
            fail      = 1'b1;
            fail_code = EXC_PROT;
            finish    = 1'b0;
        end
    end
endmodule

// File: rtl/xlate_walker.sv
module xlate_walker
    import xw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [VA_W-1:0]   asce,
    input  logic [VA_W-1:0]   vaddr,
    input  logic              is_store,
    input  logic              lf1_en,
    input  logic              lf2_en,
    output logic              mem_req,
    output logic [VA_W-1:0]   mem_addr,
    input  logic              mem_rsp_valid,
    input  logic [ENT_W-1:0]  mem_rsp_data,
    output logic              done,
    output logic              fault,
    output logic [VA_W-1:0]   result_addr,
    output logic [EXC_W-1:0]  exc_code
);
    walk_state_t      state_q, state_d;

    logic [VA_W-1:0]  ptr_q;
    logic [LVL_W-1:0] lvl_q;
    logic [VA_W-1:0]  va_q;
    logic             priv_q, store_q, lf1_q, lf2e_q, prot_q;
    logic [VA_W-1:0]  res_q;
    exc_t             exc_q;

    logic             sc_fail;
    exc_t             sc_code;
    logic [VA_W-1:0]  sc_ptr;

    logic             ev_fail, ev_finish, ev_prot;
    exc_t             ev_code;
    logic [VA_W-1:0]  ev_nptr, ev_frame;

    logic             real_mode;
    logic             unused_asce;

    assign real_mode   = asce[5];
    assign unused_asce = ^{asce[11:9], asce[7:6], asce[4]};

    xw_start_check u_start (
        .origin    (asce[VA_W-1:12]),
        .dtype     (asce[3:2]),
        .tlen      (asce[1:0]),
        .vaddr     (vaddr),
        .fail      (sc_fail),
        .fail_code (sc_code),
        .first_ptr (sc_ptr)
    );

    xw_entry_eval u_eval (
        .is_rgn    (state_q == ST_FETCH_RGN),
        .is_seg    (state_q == ST_FETCH_SEG),
        .is_pte    (state_q == ST_FETCH_PTE),
        .lvl       (lvl_q),
        .entry     (mem_rsp_data),
        .vaddr     (va_q),
        .priv      (priv_q),
        .lf1       (lf1_q),
        .lf2e      (lf2e_q),
        .is_store  (store_q),
        .prot_in   (prot_q),
        .fail      (ev_fail),
        .fail_code (ev_code),
        .finish    (ev_finish),
        .next_ptr  (ev_nptr),
        .prot_out  (ev_prot),
        .frame     (ev_frame)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    if (real_mode)             state_d = ST_DONE;
                    else if (sc_fail)          state_d = ST_FAULT;
                    else if (asce[3:2] == LVL_SEG) state_d = ST_FETCH_SEG;
                    else                       state_d = ST_FETCH_RGN;
                end
            end
            ST_FETCH_RGN: begin
                if (mem_rsp_valid) begin
                    if (ev_fail)               state_d = ST_FAULT;
                    else if (ev_finish)        state_d = ST_DONE;
                    else if (lvl_q == LVL_RGN3) state_d = ST_FETCH_SEG;
                end
            end
            ST_FETCH_SEG: begin
                if (mem_rsp_valid) begin
                    if (ev_fail)               state_d = ST_FAULT;
                    else if (ev_finish)        state_d = ST_DONE;
                    else                       state_d = ST_FETCH_PTE;
                end
            end
            ST_FETCH_PTE: begin
                if (mem_rsp_valid) begin
                    if (ev_fail)               state_d = ST_FAULT;
                    else                       state_d = ST_DONE;
                end
            end
            ST_DONE:  state_d = ST_IDLE;
            ST_FAULT: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // walk context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q   <= '0;
            lvl_q   <= '0;
            va_q    <= '0;
            priv_q  <= 1'b0;
            store_q <= 1'b0;
            lf1_q   <= 1'b0;
            lf2e_q  <= 1'b0;
            prot_q  <= 1'b0;
            res_q   <= '0;
            exc_q   <= EXC_NONE;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        va_q    <= vaddr;
                        priv_q  <= asce[8];
                        store_q <= is_store;
                        lf1_q   <= lf1_en;
                        lf2e_q  <= lf1_en & lf2_en;
                        prot_q  <= 1'b0;
                        ptr_q   <= sc_ptr;
                        lvl_q   <= asce[3:2];
                        res_q   <= vaddr;
                        exc_q   <= real_mode ? EXC_NONE : sc_code;
                    end
                end
                ST_FETCH_RGN, ST_FETCH_SEG, ST_FETCH_PTE: begin
                    if (mem_rsp_valid) begin
                        if (ev_fail) begin
                            exc_q <= ev_code;
                        end else if (ev_finish) begin
                            res_q <= ev_frame;
                            exc_q <= EXC_NONE;
                        end else begin
                            ptr_q  <= ev_nptr;
                            lvl_q  <= lvl_q - 2'd1;
                            prot_q <= ev_prot;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        mem_req = 1'b0;
        done    = 1'b0;
        fault   = 1'b0;
        unique case (state_q)
            ST_FETCH_RGN, ST_FETCH_SEG, ST_FETCH_PTE: mem_req = 1'b1;
            ST_DONE:  done = 1'b1;
            ST_FAULT: begin
                done  = 1'b1;
                fault = 1'b1;
            end
            default: ;
        endcase
    end

    assign mem_addr    = ptr_q;
    assign result_addr = res_q;
    assign exc_code    = exc_q;
endmodule

// File: rtl/xw_checker.sv
module xw_checker
    import xw_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              real_mode,
    input logic [VA_W-1:0]   vaddr,
    input walk_state_t       state_q,
    input logic              mem_req,
    input logic [VA_W-1:0]   mem_addr,
    input logic              mem_rsp_valid,
    input logic              done,
    input logic              fault,
    input logic [VA_W-1:0]   result_addr,
    input logic [EXC_W-1:0]  exc_code
);
    AST_REAL_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && start && real_mode) |=> (done && !fault && result_addr == $past(vaddr))); // R1

    AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[2:0] == 3'b000)); // R2

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R11

    AST_FAULT_HAS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault) |-> (exc_code != 8'h00)); // R11

    AST_OK_NO_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !fault) |-> (exc_code == 8'h00)); // R11

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rsp_valid) |=> (mem_req && $stable(mem_addr))); // R12

    AST_NO_REQ_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_req); // R12
endmodule

bind xlate_walker xw_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .real_mode     (asce[5]),
    .vaddr         (vaddr),
    .state_q       (state_q),
    .mem_req       (mem_req),
    .mem_addr      (mem_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .done          (done),
    .fault         (fault),
    .result_addr   (result_addr),
    .exc_code      (exc_code)
);

// File: tb/xlate_walker_test.sv
module xlate_walker_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [63:0] asce = '0;
    logic [63:0] vaddr = '0;
    logic        is_store = 1'b0;
    logic        lf1_en = 1'b0;
    logic        lf2_en = 1'b0;
    logic        mem_req;
    logic [63:0] mem_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;
    logic        done;
    logic        fault;
    logic [63:0] result_addr;
    logic [7:0]  exc_code;

    int checks = 0;
    int errors = 0;
    int lat = 0;
    int nreads = 0;
    logic [63:0] first_addr = '0;
    logic [63:0] tbl [logic [63:0]];

    always #10 clk = ~clk;   // 50 MHz

    xlate_walker uut (
        .clk(clk), .rst_n(rst_n), .start(start), .asce(asce), .vaddr(vaddr),
        .is_store(is_store), .lf1_en(lf1_en), .lf2_en(lf2_en),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .done(done), .fault(fault), .result_addr(result_addr), .exc_code(exc_code)
    );

    // absent entries read as invalid at every level (bits 5 and 10)
    function automatic logic [63:0] rd(input logic [63:0] a);
        if (tbl.exists(a)) return tbl[a];
        return 64'h420;
    endfunction

    task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // memory responder: one response per held request, after lat wait cycles
    initial begin : responder
        int waited;
        logic [63:0] seen;
        waited = 0;
        seen = '0;
        forever begin
            @(negedge clk);
            if (mem_rsp_valid) begin
                mem_rsp_valid = 1'b0;
            end else if (mem_req) begin
                if (waited == 0) begin
                    seen = mem_addr;
                    if (nreads == 0) first_addr = mem_addr;
                end else begin
                    check("R12", "held address", mem_addr, seen);
                end
                if (waited >= lat) begin
                    mem_rsp_data  = rd(mem_addr);
                    mem_rsp_valid = 1'b1;
                    waited = 0;
                    nreads++;
                end else begin
                    waited++;
                end
            end
        end
    end

    function automatic logic [7:0] lexc(input int l);
        case (l)
            3: return 8'h39;
            2: return 8'h3A;
            1: return 8'h3B;
            default: return 8'h10;
        endcase
    endfunction

    function automatic logic [10:0] vix(input logic [63:0] va, input int l);
        return 11'((va >> (20 + 11 * l)) & 64'h7ff);
    endfunction

    // model built from the requirements
    function automatic void ref_walk(input logic [63:0] a, input logic [63:0] va, input logic st,
                                     input logic l1, input logic l2,
                                     output logic [63:0] res, output logic [7:0] code);
        logic [63:0] e, p;
        logic [10:0] ix;
        logic prot, l2e, fin;
        int lvl;
        res = '0; code = 8'h00; prot = 1'b0; fin = 1'b0; l2e = l1 & l2;
        if (a[5]) begin res = va; return; end
        lvl = int'(a[3:2]);
        if (lvl < 3 && (va >> (31 + 11 * lvl)) != 0) begin code = 8'h38; return; end
        ix = vix(va, lvl);
        if (ix[10:9] > a[1:0]) begin code = lexc(lvl); return; end
        p = {a[63:12], 12'h000} + 64'(ix) * 8;
        while (lvl > 0 && !fin) begin
            e = rd(p);
            if (e[5]) begin code = lexc(lvl); return; end
            if (int'(e[3:2]) != lvl) begin code = 8'h12; return; end
            if (lvl == 1 && l2e && e[4] && a[8]) begin code = 8'h12; return; end
            if (lvl == 1 && l2e && e[10]) begin
                prot = prot | e[9];
                res = {e[63:31], va[30:0]};
                fin = 1'b1;
            end else begin
                ix = vix(va, lvl - 1);
                if (ix[10:9] < e[7:6] || ix[10:9] > e[1:0]) begin code = lexc(lvl - 1); return; end
                if (l1) prot = prot | e[9];
                p = {e[63:12], 12'h000} + 64'(ix) * 8;
                lvl--;
            end
        end
        if (!fin) begin
            e = rd(p);
            if (e[5]) begin code = 8'h10; return; end
            if (e[3:2] != 2'd0 || (e[4] && a[8])) begin code = 8'h12; return; end
            prot = prot | e[9];
            if (e[10] && l1) begin
                res = {e[63:20], va[19:0]};
                fin = 1'b1;
            end else begin
                p = {e[63:11], 11'h000} + 64'(va[19:12]) * 8;
            end
        end
        if (!fin) begin
            e = rd(p);
            if (e[10]) begin code = 8'h11; return; end
            if (e[11]) begin code = 8'h12; return; end
            prot = prot | e[9];
            res = {e[63:12], va[11:0]};
        end
        if (st && prot) code = 8'h04;
    endfunction

    function automatic string vtag(input int v);
        case (v)
            1: return "R4";
            2: return "R3";
            3, 4: return "R5";
            5, 6: return "R6";
            7, 8: return "R7";
            9, 10, 11, 17: return "R8";
            14, 15, 16: return "R10";
            default: return "R9";
        endcase
    endfunction

    // builds one table chain starting at level dt, with defect v applied
    task automatic build(input int dt, input int v, output logic [63:0] a,
                         output logic [63:0] va, output logic [63:0] exp_first);
        logic [63:0] base [4];
        logic [10:0] ix [4];
        logic [63:0] ent [4];
        logic [63:0] pte;
        logic [7:0] px;
        logic [1:0] tl;
        tbl.delete();
        base[3] = 64'h1000; base[2] = 64'h2000; base[1] = 64'h3000; base[0] = 64'h4000;
        ix[3] = 11'd1; ix[2] = 11'd2; ix[1] = 11'd3; ix[0] = 11'd5;
        px = 8'd7; tl = 2'd3;
        for (int l = dt + 1; l < 4; l++) ix[l] = '0;
        if (v == 1) begin ix[dt][9] = 1'b1; tl = 2'd0; end
        if (v == 2 && dt < 3) ix[3] = 11'h400;
        if (v == 6 && dt >= 1) ix[dt-1][9] = 1'b1;
        for (int l = 1; l < 4; l++) ent[l] = base[l-1] | 64'(l << 2) | 64'h3;
        ent[0] = 64'h5000;
        pte = 64'hABCDE000;
        a = base[dt] | 64'(dt << 2) | 64'(tl);
        case (v)
            3: ent[dt] = ent[dt] | 64'h20;
            4: ent[dt] = ent[dt] ^ 64'h4;
            5: if (dt >= 1) ent[dt] = ent[dt] | 64'h40;
            6: if (dt >= 1) ent[dt] = ent[dt] & ~64'h3;
            7: if (dt >= 1) ent[1] = (64'h5 << 31) | 64'h400 | 64'h4 | 64'h3;
            8: if (dt >= 1) begin ent[1] = ent[1] | 64'h10; a = a | 64'h100; end
            9: ent[0] = 64'h0770_0000 | 64'h400;
            10: begin ent[0] = ent[0] | 64'h10; a = a | 64'h100; end
            11: ent[0] = ent[0] | 64'h20;
            12: pte = pte | 64'h400;
            13: pte = pte | 64'h800;
            14: pte = pte | 64'h200;
            15: ent[0] = ent[0] | 64'h200;
            16: ent[dt] = ent[dt] | 64'h200;
            17: ent[0] = ent[0] | 64'h4;
            default: ;
        endcase
        for (int l = dt; l >= 0; l--) tbl[base[l] + 64'(ix[l]) * 8] = ent[l];
        tbl[64'h5000 + 64'(px) * 8] = pte;
        va = {ix[3], ix[2], ix[1], ix[0], px, 12'h123};
        exp_first = base[dt] + 64'(ix[dt]) * 8;
    endtask

    task automatic run_walk(input logic [63:0] a, input logic [63:0] va, input logic st,
                            input logic l1, input logic l2, output logic [63:0] res,
                            output logic [7:0] code, output logic flt, output logic ok);
        int guard;
        guard = 0;
        @(negedge clk);
        asce = a; vaddr = va; is_store = st; lf1_en = l1; lf2_en = l2;
        nreads = 0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done && guard < 200) begin
            @(negedge clk);
            guard++;
        end
        ok = done;
        res = result_addr; code = exc_code; flt = fault;
        @(negedge clk);
        check("R11", "done one cycle", {63'b0, done}, 64'h0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R11 watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        logic [63:0] a, va, ef, res, eres;
        logic [7:0] code, ecode;
        logic flt, ok;
        int guard;

        repeat (3) @(negedge clk);
        check("R11", "reset done", {63'b0, done}, 64'h0);
        check("R12", "reset mem_req", {63'b0, mem_req}, 64'h0);
        rst_n = 1'b1;

        // R1 real-space bypass
        run_walk(64'h1000 | 64'h20 | 64'hC, 64'hDEAD_BEEF_1234_5678, 1'b1, 1'b1, 1'b1, res, code, flt, ok);
        check("R1", "real result", res, 64'hDEAD_BEEF_1234_5678);
        check("R1", "real fault", {63'b0, flt}, 64'h0);
        check("R1", "real reads", 64'(nreads), 64'h0);

        // sweep: start level x defect x enables x access
        for (int dt = 0; dt < 4; dt++) begin
            for (int v = 0; v < 18; v++) begin
                for (int lfm = 0; lfm < 4; lfm++) begin
                    for (int st = 0; st < 2; st++) begin
                        build(dt, v, a, va, ef);
                        lat = (v + lfm + st) % 3;
                        run_walk(a, va, st[0], lfm[0], lfm[1], res, code, flt, ok);
                        ref_walk(a, va, st[0], lfm[0], lfm[1], eres, ecode);
                        check(vtag(v), "completed", {63'b0, ok}, 64'h1);
                        check(vtag(v), "exc_code", {56'b0, code}, {56'b0, ecode});
                        check("R11", "fault flag", {63'b0, flt}, {63'b0, ecode != 8'h00});
                        if (ecode == 8'h00) check(vtag(v), "result", res, eres);
                        if (v == 0) check("R2", "first read address", first_addr, ef);
                        if (v == 2 && dt < 3) check("R3", "no read on type error", 64'(nreads), 64'h0);
                    end
                end
            end
        end

        // R13: start pulses during a walk are ignored
        build(3, 0, a, va, ef);
        ref_walk(a, va, 1'b0, 1'b0, 1'b0, eres, ecode);
        lat = 2;
        @(negedge clk);
        asce = a; vaddr = va; is_store = 1'b0; lf1_en = 1'b0; lf2_en = 1'b0; start = 1'b1;
        @(negedge clk);
        asce = 64'h20; vaddr = 64'h0;
        repeat (4) @(negedge clk);
        start = 1'b0;
        guard = 0;
        while (!done && guard < 200) begin
            @(negedge clk);
            guard++;
        end
        check("R13", "walk result kept", result_addr, eres);
        check("R13", "no fault", {63'b0, fault}, 64'h0);

        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule